// File: doc/BRIEF.md
# Per-Level Endianness Byte-Lane Unit

This datapath stage sits between the load/store unit and memory. It decides, for each access, whether the bytes are handled big-endian or little-endian, and then puts them into the right lanes. Register-order write data becomes memory-order write data, and memory-order read data becomes register-order read data.

Exception levels 1, 2 and 3 each take their data byte order from a control bit of their own. Level 0 data accesses use a separate bit. Instruction fetches are always little-endian, whatever the control bits say. Only the bytes inside the access size are reordered. Read results are zero-extended to 64 bits, and write data is taken from the low bytes of the register. A parameter fixes the supported byte orders. An implementation that supports only one order overrides the control inputs to match it.

The unit is purely combinational. Its outputs follow its inputs with no added cycle.

Top module: `lane_order_unit`

## Requirements
- R1: At levels 1, 2 and 3 (`cur_level` = 1, 2, 3), a data access uses bit `cur_level`-1 of `lvl_be`: 1 means big-endian and 0 means little-endian. The other two bits of `lvl_be` and `el0_be` have no effect.
- R2: At level 0 (`cur_level` = 0), a data access uses `el0_be` (1 = big-endian), and `lvl_be` has no effect.
- R3: When `is_fetch` = 1, the access is little-endian whatever `el0_be`, `lvl_be` and `cur_level` are.
- R4: Access size is encoded on `acc_size` as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. In little-endian, `rd_data_reg` equals the low N bytes of `rd_data_mem`, with every byte above N read as zero.
- R5: In big-endian, byte i of `rd_data_reg` (bits 8i+7..8i) equals byte N-1-i of `rd_data_mem` for i < N. Bytes at N and above are zero.
- R6: Write data is taken from the low N bytes of `wr_data_reg`. These bytes are reversed in big-endian and passed unchanged in little-endian. Bytes of `wr_data_mem` at N and above are zero.
- R7: A 1-byte access is never reordered. Both outputs carry byte 0 of their input in byte 0, and zeros above it.
- R8: With the mode parameter set to little-only, every access behaves as little-endian whatever the control inputs are.
- R9: With the mode parameter set to big-only, every data access behaves as big-endian whatever the control inputs are. Fetches stay little-endian.
- R10: Both outputs follow a change of any input with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_size | input | 2 | Access size code: 0 = 1 B, 1 = 2 B, 2 = 4 B, 3 = 8 B |
| cur_level | input | 2 | Current exception level, 0 to 3 |
| el0_be | input | 1 | Data byte order for level 0 (1 = big-endian) |
| lvl_be | input | 3 | Data byte order for levels 1..3; bit k belongs to level k+1 |
| is_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| wr_data_reg | input | 64 | Store data in register order |
| rd_data_mem | input | 64 | Load data as returned by memory |
| wr_data_mem | output | 64 | Store data in memory order |
| rd_data_reg | output | 64 | Load data in register order, zero-extended |

## Verification
A distinct-byte pattern (0x11..0x88) is driven at every size in both byte orders. Because every byte value is different, any wrong lane, wrong reversal length or stray upper byte shows up in the result. Level selection is checked by setting only the bit of the active level, and then every bit except that one. This separates the use of the level's own bit from the use of a neighbour's bit or of the level-0 bit. Fetches are driven with every control bit set, and three instances with different mode parameters receive the same stimulus, so that forced orders can be told apart from selected ones.

// File: rtl/lane_order_pkg.sv
package lane_order_pkg;

    // Byte orders that an implementation supports
    typedef enum int {
        ORD_BOTH   = 0,
        ORD_LITTLE = 1,
        ORD_BIG    = 2
    } ord_mode_e;

    // Access size codes
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

endpackage

// File: rtl/lane_order_sel.sv
module lane_order_sel
    import lane_order_pkg::*;
#(
    parameter ord_mode_e MODE = ORD_BOTH,
    parameter int        LVLS = 4,
    localparam int       LVLW = $clog2(LVLS)
) (
    input  logic [LVLW-1:0] level,
    input  logic            lvl0_big,
    input  logic [LVLS-2:0] upper_big,
    input  logic            fetch,
    output logic            big
);

    logic sel_d;
    logic tied_d;

    // Pick the control bit that belongs to the active level
    always_comb begin
        sel_d = lvl0_big;
        for (int i = 1; i < LVLS; i++) begin
            if (level == LVLW'(i)) begin
                sel_d = upper_big[i-1];
            end
        end
    end

    // Implementations with a single byte order ignore the controls
    generate
        if (MODE == ORD_LITTLE) begin : g_little
            assign tied_d = 1'b0;
        end else if (MODE == ORD_BIG) begin : g_big
            assign tied_d = 1'b1;
        end else begin : g_both
            assign tied_d = sel_d;
        end
    endgenerate

    // Fetches never swap
    assign big = tied_d & ~fetch;

endmodule

// File: rtl/lane_order_swap.sv
module lane_order_swap #(
    parameter int  BYTES = 8,
    localparam int SZW   = $clog2($clog2(BYTES) + 1),
    localparam int DW    = BYTES * 8
) (
    input  logic [DW-1:0]  din,
    input  logic [SZW-1:0] size,
    input  logic           swap,
    output logic [DW-1:0]  dout
);

    int nbytes_d;

    always_comb begin
        nbytes_d = 1 << size;
        dout     = '0;
        for (int i = 0; i < BYTES; i++) begin
            if (i < nbytes_d) begin
                if (swap) begin
                    dout[i*8 +: 8] = din[(nbytes_d - 1 - i)*8 +: 8];
                end else begin
                    dout[i*8 +: 8] = din[i*8 +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/lane_order_unit.sv
module lane_order_unit
    import lane_order_pkg::*;
#(
    parameter ord_mode_e MODE  = ORD_BOTH,
    parameter int        BYTES = 8,
    parameter int        LVLS  = 4,
    localparam int       DW    = BYTES * 8,
    localparam int       SZW   = $clog2($clog2(BYTES) + 1),
    localparam int       LVLW  = $clog2(LVLS)
) (
    input  logic [SZW-1:0]  acc_size,
    input  logic [LVLW-1:0] cur_level,
    input  logic            el0_be,
    input  logic [LVLS-2:0] lvl_be,
    input  logic            is_fetch,
    input  logic [DW-1:0]   wr_data_reg,
    input  logic [DW-1:0]   rd_data_mem,
    output logic [DW-1:0]   wr_data_mem,
    output logic [DW-1:0]   rd_data_reg
);

    logic big_d;

    lane_order_sel #(
        .MODE (MODE),
        .LVLS (LVLS)
    ) i_sel (
        .level     (cur_level),
        .lvl0_big  (el0_be),
        .upper_big (lvl_be),
        .fetch     (is_fetch),
        .big       (big_d)
    );

    // Store path: register order to memory order
    lane_order_swap #(
        .BYTES (BYTES)
    ) i_wr_swap (
        .din  (wr_data_reg),
        .size (acc_size),
        .swap (big_d),
        .dout (wr_data_mem)
    );

    // Load path: memory order to register order, zero-extended
    lane_order_swap #(
        .BYTES (BYTES)
    ) i_rd_swap (
        .din  (rd_data_mem),
        .size (acc_size),
        .swap (big_d),
        .dout (rd_data_reg)
    );

endmodule

// File: rtl/lane_order_chk.sv
module lane_order_chk
    import lane_order_pkg::*;
#(
    parameter ord_mode_e MODE  = ORD_BOTH,
    parameter int        BYTES = 8,
    parameter int        LVLS  = 4,
    localparam int       DW    = BYTES * 8,
    localparam int       SZW   = $clog2($clog2(BYTES) + 1),
    localparam int       LVLW  = $clog2(LVLS)
) (
    input logic [SZW-1:0]  acc_size,
    input logic [LVLW-1:0] cur_level,
    input logic            el0_be,
    input logic [LVLS-2:0] lvl_be,
    input logic            is_fetch,
    input logic [DW-1:0]   wr_data_reg,
    input logic [DW-1:0]   rd_data_mem,
    input logic [DW-1:0]   wr_data_mem,
    input logic [DW-1:0]   rd_data_reg
);

    logic [DW-1:0] msk;
    logic          known;

    always_comb begin
        msk = '0;
        for (int i = 0; i < BYTES; i++) begin
            if (i < (1 << acc_size)) begin
                msk[i*8 +: 8] = 8'hFF;
            end
        end
        known = !$isunknown({acc_size, cur_level, el0_be, lvl_be, is_fetch,
                             wr_data_reg, rd_data_mem, wr_data_mem, rd_data_reg});
    end

    always_comb begin
        if (known) begin
            // R7
            byte_rd_plain_chk: assert (acc_size != '0 ||
                rd_data_reg == {{(DW-8){1'b0}}, rd_data_mem[7:0]});
            // R7
            byte_wr_plain_chk: assert (acc_size != '0 ||
                wr_data_mem == {{(DW-8){1'b0}}, wr_data_reg[7:0]});
            // R3
            fetch_little_chk: assert (!is_fetch ||
                (rd_data_reg == (rd_data_mem & msk) && wr_data_mem == (wr_data_reg & msk)));
            // R5
            rd_upper_zero_chk: assert ((rd_data_reg & ~msk) == '0);
            // R6
            wr_upper_zero_chk: assert ((wr_data_mem & ~msk) == '0);
            // R4
            rd_bits_kept_chk: assert ($countones(rd_data_reg) == $countones(rd_data_mem & msk));
            // R8
            little_only_chk: assert (MODE != ORD_LITTLE || rd_data_reg == (rd_data_mem & msk));
        end
    end

endmodule

bind lane_order_unit lane_order_chk #(
    .MODE  (MODE),
    .BYTES (BYTES),
    .LVLS  (LVLS)
) i_lane_order_chk (
    .acc_size    (acc_size),
    .cur_level   (cur_level),
    .el0_be      (el0_be),
    .lvl_be      (lvl_be),
    .is_fetch    (is_fetch),
    .wr_data_reg (wr_data_reg),
    .rd_data_mem (rd_data_mem),
    .wr_data_mem (wr_data_mem),
    .rd_data_reg (rd_data_reg)
);

// File: tb/test_lane_order_unit.sv
`timescale 1ns/1ps
module test_lane_order_unit;
    import lane_order_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  acc_size = '0;
    logic [1:0]  cur_level = '0;
    logic        el0_be = 1'b0;
    logic [2:0]  lvl_be = '0;
    logic        is_fetch = 1'b0;
    logic [63:0] wr_data_reg = '0;
    logic [63:0] rd_data_mem = '0;
    logic [63:0] wr_b, rd_b, wr_l, rd_l, wr_g, rd_g;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lane_order_unit #(.MODE(ORD_BOTH)) i_lane_order_unit (
        .acc_size(acc_size), .cur_level(cur_level), .el0_be(el0_be), .lvl_be(lvl_be),
        .is_fetch(is_fetch), .wr_data_reg(wr_data_reg), .rd_data_mem(rd_data_mem),
        .wr_data_mem(wr_b), .rd_data_reg(rd_b));

    lane_order_unit #(.MODE(ORD_LITTLE)) i_lane_order_unit_le (
        .acc_size(acc_size), .cur_level(cur_level), .el0_be(el0_be), .lvl_be(lvl_be),
        .is_fetch(is_fetch), .wr_data_reg(wr_data_reg), .rd_data_mem(rd_data_mem),
        .wr_data_mem(wr_l), .rd_data_reg(rd_l));

    lane_order_unit #(.MODE(ORD_BIG)) i_lane_order_unit_be (
        .acc_size(acc_size), .cur_level(cur_level), .el0_be(el0_be), .lvl_be(lvl_be),
        .is_fetch(is_fetch), .wr_data_reg(wr_data_reg), .rd_data_mem(rd_data_mem),
        .wr_data_mem(wr_g), .rd_data_reg(rd_g));

    localparam logic [63:0] PAT = 64'h1122334455667788;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive away from the clock edge; outputs are read 1 ns later with no edge between
    task automatic drive(input logic [1:0] sz, input logic [1:0] lv, input logic e0,
                         input logic [2:0] lb, input logic f,
                         input logic [63:0] w, input logic [63:0] r);
        @(negedge clk);
        acc_size = sz; cur_level = lv; el0_be = e0; lvl_be = lb; is_fetch = f;
        wr_data_reg = w; rd_data_mem = r;
        #1;
    endtask

    // Requirement-level model of the load/store result
    function automatic logic [63:0] order(input logic [63:0] d, input logic [1:0] sz, input bit big);
        logic [63:0] o = '0;
        int n = 1 << sz;
        for (int i = 0; i < n; i++) begin
            o[i*8 +: 8] = big ? d[(n-1-i)*8 +: 8] : d[i*8 +: 8];
        end
        return o;
    endfunction

    task automatic t_idle();
        drive(2'd0, 2'd0, 1'b0, 3'b000, 1'b0, 64'd0, 64'd0);
        chk("R4 idle rd", rd_b, 64'd0);
        chk("R6 idle wr", wr_b, 64'd0);
    endtask

    task automatic t_levels();
        for (int lv = 1; lv < 4; lv++) begin
            drive(2'd3, 2'(lv), 1'b0, 3'(1 << (lv-1)), 1'b0, PAT, PAT);
            chk("R1 own bit set", rd_b, 64'h8877665544332211);
            drive(2'd3, 2'(lv), 1'b1, ~3'(1 << (lv-1)), 1'b0, PAT, PAT);
            chk("R1 own bit clear", rd_b, PAT);
        end
    endtask

    task automatic t_level0();
        drive(2'd2, 2'd0, 1'b1, 3'b000, 1'b0, PAT, PAT);
        chk("R2 el0 big", rd_b, 64'h0000000088776655);
        drive(2'd2, 2'd0, 1'b0, 3'b111, 1'b0, PAT, PAT);
        chk("R2 el0 little", rd_b, 64'h0000000055667788);
    endtask

    task automatic t_fetch();
        for (int lv = 0; lv < 4; lv++) begin
            drive(2'd3, 2'(lv), 1'b1, 3'b111, 1'b1, PAT, PAT);
            chk("R3 fetch rd", rd_b, PAT);
            chk("R3 fetch wr", wr_b, PAT);
            chk("R9 fetch big-only", rd_g, PAT);
        end
    endtask

    task automatic t_sizes();
        drive(2'd1, 2'd1, 1'b0, 3'b001, 1'b0, PAT, PAT);
        chk("R5 half big", rd_b, 64'h0000000000008877);
        drive(2'd1, 2'd1, 1'b0, 3'b000, 1'b0, PAT, PAT);
        chk("R4 half little", rd_b, 64'h0000000000007788);
        drive(2'd2, 2'd2, 1'b0, 3'b000, 1'b0, PAT, PAT);
        chk("R4 word little", rd_b, 64'h0000000055667788);
        drive(2'd3, 2'd3, 1'b0, 3'b100, 1'b0, PAT, PAT);
        chk("R5 dword big", rd_b, 64'h8877665544332211);
    endtask

    task automatic t_write();
        drive(2'd2, 2'd3, 1'b0, 3'b100, 1'b0, PAT, 64'd0);
        chk("R6 word big wr", wr_b, 64'h0000000088776655);
        drive(2'd1, 2'd3, 1'b0, 3'b000, 1'b0, PAT, 64'd0);
        chk("R6 half little wr", wr_b, 64'h0000000000007788);
        drive(2'd3, 2'd2, 1'b0, 3'b010, 1'b0, 64'h0102030405060708, 64'd0);
        chk("R6 dword big wr", wr_b, 64'h0807060504030201);
    endtask

    task automatic t_byte();
        drive(2'd0, 2'd1, 1'b1, 3'b111, 1'b0, PAT, PAT);
        chk("R7 byte rd", rd_b, 64'h88);
        chk("R7 byte wr", wr_b, 64'h88);
        chk("R7 byte big-only", rd_g, 64'h88);
    endtask

    task automatic t_modes();
        drive(2'd3, 2'd0, 1'b1, 3'b111, 1'b0, PAT, PAT);
        chk("R8 little-only rd", rd_l, PAT);
        chk("R8 little-only wr", wr_l, PAT);
        drive(2'd2, 2'd1, 1'b0, 3'b000, 1'b0, PAT, PAT);
        chk("R9 big-only rd", rd_g, 64'h0000000088776655);
        chk("R9 big-only wr", wr_g, 64'h0000000088776655);
    endtask

    task automatic t_comb();
        // R10: change inputs and read at once, no edge between
        @(posedge clk);
        #1;
        acc_size = 2'd3; cur_level = 2'd2; lvl_be = 3'b010; is_fetch = 1'b0;
        rd_data_mem = 64'hA1B2C3D4E5F60718;
        #1;
        chk("R10 same-cycle", rd_b, 64'h1807F6E5D4C3B2A1);
    endtask

    task automatic t_sweep();
        for (int sz = 0; sz < 4; sz++) begin
            for (int lv = 0; lv < 4; lv++) begin
                for (int cb = 0; cb < 16; cb++) begin
                    for (int f = 0; f < 2; f++) begin
                        bit big;
                        logic [63:0] w = 64'hF0E1D2C3B4A59687 ^ 64'(cb * 977 + lv);
                        logic [63:0] r = 64'h0F1E2D3C4B5A6978 + 64'(sz * 131 + cb);
                        drive(2'(sz), 2'(lv), cb[3], 3'(cb), f[0], w, r);
                        big = (f == 0) && ((lv == 0) ? cb[3] : cb[lv-1]);
                        chk("R1 R2 R3 sweep rd", rd_b, order(r, 2'(sz), big));
                        chk("R6 sweep wr", wr_b, order(w, 2'(sz), big));
                        chk("R8 sweep", rd_l, order(r, 2'(sz), 1'b0));
                        chk("R9 sweep", rd_g, order(r, 2'(sz), f == 0));
                    end
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_levels();
        t_level0();
        t_fetch();
        t_sizes();
        t_write();
        t_byte();
        t_modes();
        t_comb();
        t_sweep();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog got timeout expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule